// File: doc/BRIEF.md
# SDR SDRAM Controller with Periodic Refresh

This block sits between a simple single-word request port and one 16-bit, four-bank synchronous DRAM. After reset it brings the memory up on its own: it waits out a power-up delay with the clock enable low, precharges every bank, runs two auto refresh cycles and programs the mode register. Only then does it accept user requests.

Each accepted request is served as a closed-page access. The controller opens the addressed row, issues one read or write with auto-precharge, and keeps the memory idle until the bank has closed again. Write data carries two byte enables, which drive the two data mask pins. Read data is captured a programmable CAS latency (2 or 3) after the read command. It comes back with a one-cycle valid strobe. An internal interval counter requests an auto refresh at a fixed period. The controller serves the refresh ahead of new requests, but never in the middle of an access. Every timing limit is a clock-cycle count set by a parameter.

Top module: `sdram_ctrl`

## Requirements
- R1: From reset release, the clock enable stays low and the command pins carry NOP for at least T_INIT-1 cycles, and req_ready stays low throughout. During that time no command other than NOP may appear.
- R2: The bring-up sequence issues four commands in this order: a precharge with address bit 10 high (all banks), two auto refreshes, then a mode register load. The mode register load carries this address word: bits 2:0 = 000 (one-word bursts), bit 3 = 0 (sequential), bits 6:4 = CAS latency, bit 9 = 0, all other bits 0. req_ready rises only after this sequence.
- R3: Commands are coded on {cs_n, ras_n, cas_n, we_n}. The codes are: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, mode load 0000. No other code is ever driven.
- R4: The request address is split as {bank[22:21], row[20:9], column[8:0]}. Each request produces one activate to that bank and row. It then produces one read or write to that column with address bit 10 high (auto-precharge).
- R5: The read or write follows its activate by at least max(T_RCD, T_RAS) cycles. This covers both the activate-to-access delay and the minimum row-active time before the internal precharge.
- R6: Spacing rules for the next activate, precharge or refresh:
  - After a read or write with auto-precharge, it comes no sooner than T_WR+T_RP cycles later.
  - After a precharge, the next command comes no sooner than T_RP cycles later.
  - After a refresh, the next command comes no sooner than T_RFC cycles later.
  - After a mode load, the next command comes no sooner than T_MRD cycles later.
- R7: A write drives the data bus, with the output enable high, only in the cycle of its write command. dqm[1] is high exactly when be[1] is 0, masking the upper byte. dqm[0] is high exactly when be[0] is 0, masking the lower byte.
- R8: Read data present on the bus CAS_LAT cycles after the read command appears on rd_data. rd_valid is high for exactly one cycle, the cycle that starts CAS_LAT clock edges after the read command, once per read.
- R9: Once bring-up is done, a refresh is requested every T_REFI cycles. It is served by a precharge-all and then an auto refresh. It wins over a waiting user request. No command other than NOP ever appears between an activate and its read or write.
- R10: req_ready is high only when the controller is idle and no refresh is waiting. A request is taken when req_valid and req_ready are both high at a clock edge. The activate follows on the next cycle, and req_ready stays low until the access has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | User request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | {bank, row, column} word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for write data |
| rd_valid | output | 1 | One-cycle strobe for returned read data |
| rd_data | output | 16 | Returned read data |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Memory chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed row/column address |
| sd_dqm | output | 2 | Byte data masks |
| sd_dq_out | output | 16 | Data driven toward the memory |
| sd_dq_oe | output | 1 | Output enable for sd_dq_out |
| sd_dq_in | input | 16 | Data returned from the memory |

## Verification
The embedded properties watch local cycle relations on every cycle:
- an accepted request is followed by an activate;
- every access carries the auto-precharge bit and comes after a NOP;
- the data bus is driven only with a write command;
- the clock enable stays low only while NOP is on the bus;
- a pending refresh is held until it is acknowledged;
- rd_valid follows a read by exactly the CAS latency.

The multi-command spacing rules, the bring-up order and mode word, the address split, the byte masking, the refresh period and the refresh priority under load are only shown by the bench's scenarios. In those scenarios a behavioural memory model decodes the pins, stores data and times every command against its predecessors.

// File: rtl/sdram_pkg.sv
// Shared types for the SDRAM controller.
// Assumes a single-rank SDR part driven by one command per clock.
package sdram_pkg;

    // Pin code {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } cmd_t;

    typedef enum logic [2:0] {
        ST_PWR,
        ST_INIT_PRE,
        ST_INIT_REF,
        ST_INIT_MRS,
        ST_IDLE,
        ST_REF,
        ST_RW,
        ST_WAIT
    } seq_state_t;

endpackage

// File: rtl/sdram_refresh_timer.sv
// Refresh interval counter.
// Counts T_REFI cycles while run is high and raises pending; pending
// is held until the sequencer acknowledges the refresh it issued.
// Assumes one interval is far longer than any single access.
module sdram_refresh_timer #(
    parameter int T_REFI = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(T_REFI + 1);

    logic [CW-1:0] cnt;

    // Interval count and pending flag; a new tick wins over an ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            if (ack)
                pending <= 1'b0;
            if (run) begin
                if (cnt == CW'(T_REFI - 1)) begin
                    cnt     <= '0;
                    pending <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack) |=> pending);

endmodule

// File: rtl/sdram_rd_capture.sv
// Read data capture.
// Samples the memory data bus CAS_LAT edges after a read command left
// the controller and presents it with a one-cycle valid strobe.
// Assumes CAS_LAT is 2 or 3 and reads are at least two cycles apart.
module sdram_rd_capture #(
    parameter int DATA_W  = 16,
    parameter int CAS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int TAP = CAS_LAT - 2;

    logic [1:0] sh;

    // Latency shift line, valid strobe and data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            sh       <= {sh[0], rd_issue};
            rd_valid <= sh[TAP];
            if (sh[TAP])
                rd_data <= dq_in;
        end
    end

    // R8
    rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_issue, CAS_LAT) |-> rd_valid);

    // R8
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/sdram_cmd_seq.sv
// Command sequencer.
// Runs the bring-up order, then serves one single-word access at a time
// as activate -> read/write with auto-precharge, and inserts
// precharge-all + auto refresh when the timer asks. All pin outputs are
// registered. Each wait is loaded as N-1 and leaves through ST_WAIT, so
// the pin spacing is N+1 cycles.
module sdram_cmd_seq
    import sdram_pkg::*;
#(
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 12,
    parameter int COL_W   = 9,
    parameter int DATA_W  = 16,
    parameter int CAS_LAT = 2,
    parameter int T_INIT  = 20000,
    parameter int T_RCD   = 2,
    parameter int T_RP    = 2,
    parameter int T_RAS   = 5,
    parameter int T_WR    = 2,
    parameter int T_RFC   = 7,
    parameter int T_MRD   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_we,
    input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    input  logic [DATA_W/8-1:0]           req_be,
    input  logic                          ref_pending,
    output logic                          req_ready,
    output logic                          ref_ack,
    output logic                          init_done,
    output cmd_t                          cmd,
    output logic [BANK_W-1:0]             ba,
    output logic [ROW_W-1:0]              addr,
    output logic [DATA_W/8-1:0]           dqm,
    output logic                          cke,
    output logic [DATA_W-1:0]             dq_out,
    output logic                          dq_oe,
    output logic                          rd_issue
);
    localparam int ACT_GAP  = (T_RCD > T_RAS) ? T_RCD : T_RAS;
    localparam int POST_GAP = T_WR + T_RP;
    localparam int CNT_W    = $clog2(T_INIT + T_RFC + ACT_GAP + POST_GAP + T_MRD + 2);
    localparam int AP_BIT   = 10;
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

    seq_state_t          state, ret;
    logic [CNT_W-1:0]    cnt;
    logic                second_ref;
    logic                lat_we;
    logic [BANK_W-1:0]   lat_bank;
    logic [COL_W-1:0]    lat_col;
    logic [DATA_W-1:0]   lat_wdata;
    logic [DATA_W/8-1:0] lat_be;

    // Requests are taken only when idle with no refresh waiting.
    always_comb req_ready = (state == ST_IDLE) && !ref_pending;

    // Main sequencer: command choice, wait loading and request latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_PWR;
            ret        <= ST_IDLE;
            cnt        <= CNT_W'(T_INIT - 1);
            second_ref <= 1'b0;
            init_done  <= 1'b0;
            cke        <= 1'b0;
            cmd        <= CMD_NOP;
            ba         <= '0;
            addr       <= '0;
            dqm        <= '0;
            dq_out     <= '0;
            dq_oe      <= 1'b0;
            rd_issue   <= 1'b0;
            ref_ack    <= 1'b0;
            lat_we     <= 1'b0;
            lat_bank   <= '0;
            lat_col    <= '0;
            lat_wdata  <= '0;
            lat_be     <= '0;
        end else begin
            cmd      <= CMD_NOP;
            dqm      <= '0;
            dq_oe    <= 1'b0;
            rd_issue <= 1'b0;
            ref_ack  <= 1'b0;
            unique case (state)
                ST_PWR: begin
                    if (cnt == '0) begin
                        cke   <= 1'b1;
                        state <= ST_INIT_PRE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_INIT_PRE: begin
                    cmd          <= CMD_PRE;
                    addr         <= '0;
                    addr[AP_BIT] <= 1'b1;
                    cnt          <= CNT_W'(T_RP - 1);
                    ret          <= ST_INIT_REF;
                    state        <= ST_WAIT;
                end
                ST_INIT_REF: begin
                    cmd        <= CMD_REF;
                    cnt        <= CNT_W'(T_RFC - 1);
                    ret        <= second_ref ? ST_INIT_MRS : ST_INIT_REF;
                    second_ref <= 1'b1;
                    state      <= ST_WAIT;
                end
                ST_INIT_MRS: begin
                    cmd       <= CMD_MRS;
                    ba        <= '0;
                    addr      <= MODE_WORD;
                    cnt       <= CNT_W'(T_MRD - 1);
                    ret       <= ST_IDLE;
                    init_done <= 1'b1;
                    state     <= ST_WAIT;
                end
                ST_IDLE: begin
                    if (ref_pending) begin
                        cmd          <= CMD_PRE;
                        addr         <= '0;
                        addr[AP_BIT] <= 1'b1;
                        cnt          <= CNT_W'(T_RP - 1);
                        ret          <= ST_REF;
                        state        <= ST_WAIT;
                    end else if (req_valid) begin
                        cmd       <= CMD_ACT;
                        ba        <= req_addr[BANK_W+ROW_W+COL_W-1 -: BANK_W];
                        addr      <= req_addr[ROW_W+COL_W-1 -: ROW_W];
                        lat_we    <= req_we;
                        lat_bank  <= req_addr[BANK_W+ROW_W+COL_W-1 -: BANK_W];
                        lat_col   <= req_addr[COL_W-1:0];
                        lat_wdata <= req_wdata;
                        lat_be    <= req_be;
                        cnt       <= CNT_W'(ACT_GAP - 1);
                        ret       <= ST_RW;
                        state     <= ST_WAIT;
                    end
                end
                ST_REF: begin
                    cmd     <= CMD_REF;
                    ref_ack <= 1'b1;
                    cnt     <= CNT_W'(T_RFC - 1);
                    ret     <= ST_IDLE;
                    state   <= ST_WAIT;
                end
                ST_RW: begin
                    cmd                <= lat_we ? CMD_WR : CMD_RD;
                    ba                 <= lat_bank;
                    addr               <= '0;
                    addr[COL_W-1:0]    <= lat_col;
                    addr[AP_BIT]       <= 1'b1;
                    dqm                <= lat_we ? ~lat_be : '0;
                    dq_out             <= lat_wdata;
                    dq_oe              <= lat_we;
                    rd_issue           <= !lat_we;
                    cnt                <= CNT_W'(POST_GAP - 1);
                    ret                <= ST_IDLE;
                    state              <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (cnt == '0)
                        state <= ret;
                    else
                        cnt <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10
    accept_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd == CMD_ACT));

    // R4
    rw_ap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |-> addr[AP_BIT]);

    // R5
    rw_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |-> ($past(cmd) == CMD_NOP));

    // R1
    cke_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cmd == CMD_NOP));

    // R7
    wr_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (cmd == CMD_WR));

endmodule

// File: rtl/sdram_ctrl.sv
// SDR SDRAM controller top.
// Ties the command sequencer, refresh timer and read capture together
// and splits the command code onto the four strobe pins.
// Assumes the data bus is split into in/out/enable at the pad level.
module sdram_ctrl
    import sdram_pkg::*;
#(
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 12,
    parameter int COL_W   = 9,
    parameter int DATA_W  = 16,
    parameter int CAS_LAT = 2,
    parameter int T_INIT  = 20000,
    parameter int T_RCD   = 2,
    parameter int T_RP    = 2,
    parameter int T_RAS   = 5,
    parameter int T_WR    = 2,
    parameter int T_RFC   = 7,
    parameter int T_MRD   = 2,
    parameter int T_REFI  = 1500
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_we,
    input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    input  logic [DATA_W/8-1:0]           req_be,
    output logic                          rd_valid,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          sd_cke,
    output logic                          sd_cs_n,
    output logic                          sd_ras_n,
    output logic                          sd_cas_n,
    output logic                          sd_we_n,
    output logic [BANK_W-1:0]             sd_ba,
    output logic [ROW_W-1:0]              sd_addr,
    output logic [DATA_W/8-1:0]           sd_dqm,
    output logic [DATA_W-1:0]             sd_dq_out,
    output logic                          sd_dq_oe,
    input  logic [DATA_W-1:0]             sd_dq_in
);
    cmd_t cmd;
    logic ref_pending, ref_ack, init_done, rd_issue;

    // Command code onto the strobe pins.
    always_comb {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    sdram_cmd_seq #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .CAS_LAT(CAS_LAT), .T_INIT(T_INIT), .T_RCD(T_RCD), .T_RP(T_RP),
        .T_RAS(T_RAS), .T_WR(T_WR), .T_RFC(T_RFC), .T_MRD(T_MRD)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .ref_pending(ref_pending), .req_ready(req_ready), .ref_ack(ref_ack),
        .init_done(init_done), .cmd(cmd), .ba(sd_ba), .addr(sd_addr),
        .dqm(sd_dqm), .cke(sd_cke), .dq_out(sd_dq_out), .dq_oe(sd_dq_oe),
        .rd_issue(rd_issue)
    );

    sdram_refresh_timer #(.T_REFI(T_REFI)) u_refresh (
        .clk(clk), .rst_n(rst_n), .run(init_done), .ack(ref_ack),
        .pending(ref_pending)
    );

    sdram_rd_capture #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) u_capture (
        .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .dq_in(sd_dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

endmodule

// File: tb/sdram_ctrl_test.sv
// Directed bench with a behavioural memory model that decodes the pins.
module sdram_ctrl_test;
    localparam int CL     = 3;
    localparam int TINIT  = 40;
    localparam int TRCD   = 2;
    localparam int TRP    = 2;
    localparam int TRAS   = 4;
    localparam int TWR    = 2;
    localparam int TRFC   = 6;
    localparam int TMRD   = 2;
    localparam int TREFI  = 300;
    localparam int ACTGAP = (TRCD > TRAS) ? TRCD : TRAS;
    localparam logic [15:0] JUNK = 16'h5A5A;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [22:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0] req_be = 2'b11;
    logic req_ready, rd_valid;
    logic [15:0] rd_data;
    logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0] sd_ba, sd_dqm;
    logic [11:0] sd_addr;
    logic [15:0] sd_dq_out;
    logic [15:0] sd_dq_in = JUNK;

    int tests = 0, fails = 0, cyc = 0;

    sdram_ctrl #(.CAS_LAT(CL), .T_INIT(TINIT), .T_RCD(TRCD), .T_RP(TRP),
        .T_RAS(TRAS), .T_WR(TWR), .T_RFC(TRFC), .T_MRD(TMRD), .T_REFI(TREFI)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [15:0] mem [int];
    bit open_b [4];
    int act_cyc [4];
    int last_pre = -1000, last_rw = -1000, last_ref = -1000, last_mrs = -1000;
    int v_gap = 0, v_bank = 0, v_ap = 0, v_unk = 0, v_intr = 0, v_lat = 0, v_oe = 0;
    int nlog = 0;
    logic [3:0] log_cmd [4];
    logic [11:0] log_addr [4];
    int ref_cnt = 0, iv_min = 1000000, iv_max = 0;
    int rd_cmd_cyc = -1, pend_cnt = 0;
    logic [15:0] pend_val = '0;

    function automatic int key(input logic [1:0] b, input logic [11:0] r, input logic [8:0] c);
        return int'({b, r, c});
    endfunction

    function automatic logic [15:0] peek(input int k);
        if (mem.exists(k)) return mem[k];
        return k[15:0] ^ 16'hC3C3;
    endfunction

    function automatic bit any_open();
        return open_b[0] | open_b[1] | open_b[2] | open_b[3];
    endfunction

    always @(negedge clk) begin
        logic [3:0] c;
        int k;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        sd_dq_in = JUNK;
        if (pend_cnt != 0) begin
            pend_cnt = pend_cnt - 1;
            if (pend_cnt == 0) sd_dq_in = pend_val;
        end
        if (rst_n) begin
            if (rd_valid && (rd_cmd_cyc < 0 || cyc != rd_cmd_cyc + CL)) v_lat++;
            if (sd_dq_oe && c != 4'b0100) v_oe++;
            if (c != 4'b0111 && nlog < 4) begin
                log_cmd[nlog] = c; log_addr[nlog] = sd_addr; nlog++;
            end
            case (c)
                4'b0111: ;
                4'b0011: begin
                    if (any_open()) v_intr++;
                    if (cyc - last_pre < TRP || cyc - last_rw < TWR + TRP ||
                        cyc - last_ref < TRFC || cyc - last_mrs < TMRD) v_gap++;
                    open_b[sd_ba] = 1'b1; act_cyc[sd_ba] = cyc;
                    act_row[sd_ba] = sd_addr;
                end
                4'b0100, 4'b0101: begin
                    if (!open_b[sd_ba]) v_bank++;
                    if (cyc - act_cyc[sd_ba] < ACTGAP) v_gap++;
                    if (!sd_addr[10]) v_ap++;
                    k = key(sd_ba, act_row[sd_ba], sd_addr[8:0]);
                    if (c == 4'b0100) begin
                        logic [15:0] w;
                        w = peek(k);
                        if (!sd_dqm[1]) w[15:8] = sd_dq_out[15:8];
                        if (!sd_dqm[0]) w[7:0] = sd_dq_out[7:0];
                        if (!sd_dq_oe) v_oe++;
                        mem[k] = w;
                    end else begin
                        pend_val = peek(k); pend_cnt = CL - 1; rd_cmd_cyc = cyc;
                    end
                    open_b[sd_ba] = 1'b0; last_rw = cyc;
                end
                4'b0010: begin
                    if (any_open()) v_intr++;
                    if (cyc - last_rw < TWR + TRP || cyc - last_ref < TRFC) v_gap++;
                    if (sd_addr[10]) for (int b = 0; b < 4; b++) open_b[b] = 1'b0;
                    last_pre = cyc;
                end
                4'b0001: begin
                    if (any_open()) v_intr++;
                    if (cyc - last_pre < TRP || cyc - last_ref < TRFC) v_gap++;
                    ref_cnt++;
                    if (ref_cnt > 3) begin
                        if (cyc - last_ref < iv_min) iv_min = cyc - last_ref;
                        if (cyc - last_ref > iv_max) iv_max = cyc - last_ref;
                    end
                    last_ref = cyc;
                end
                4'b0000: begin
                    if (cyc - last_ref < TRFC) v_gap++;
                    last_mrs = cyc;
                end
                default: v_unk++;
            endcase
        end
    end
    logic [11:0] act_row [4];

    // ---------------- user port tasks ----------------
    task automatic issue(input bit we, input logic [22:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // R10: ready drops once a request is taken
        chk(req_ready == 1'b0, "R10 ready low after accept", req_ready, 0);
    endtask

    task automatic read_chk(input logic [22:0] a, input logic [15:0] exp, input string tag);
        int n;
        issue(1'b0, a, 16'h0, 2'b11);
        n = 0;
        while (!rd_valid && n < 100) begin @(negedge clk); n++; end
        chk(rd_valid && rd_data == exp, tag, rd_data, exp);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        int lowc;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(sd_cke == 1'b0 && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111,
            "R1 cke low and NOP after reset", {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 5'b00111);
        lowc = 0;
        repeat (TINIT - 3) begin
            @(negedge clk);
            if (sd_cke || req_ready) lowc++;
        end
        chk(lowc == 0, "R1 cke and ready low during power-up", lowc, 0);
    endtask

    task automatic t_init();
        int n;
        n = 0;
        while (!req_ready && n < 200) begin @(negedge clk); n++; end
        chk(req_ready && sd_cke, "R2 ready and cke high after bring-up", {req_ready, sd_cke}, 2'b11);
        chk(nlog == 4, "R2 command count in bring-up", nlog, 4);
        chk(log_cmd[0] == 4'b0010 && log_addr[0][10], "R2 first is precharge-all", {log_cmd[0], log_addr[0]}, {4'b0010, 12'h400});
        chk(log_cmd[1] == 4'b0001 && log_cmd[2] == 4'b0001, "R2 two refreshes", {log_cmd[1], log_cmd[2]}, 8'h11);
        chk(log_cmd[3] == 4'b0000, "R2 mode load last", log_cmd[3], 0);
        chk(log_addr[3] == 12'(CL << 4), "R2 mode word", log_addr[3], CL << 4);
    endtask

    task automatic t_basic();
        issue(1'b1, {2'd1, 12'h0A5, 9'h013}, 16'hBEEF, 2'b11);
        read_chk({2'd1, 12'h0A5, 9'h013}, 16'hBEEF, "R4 R8 write then read");
        issue(1'b1, {2'd0, 12'hFFF, 9'h1FF}, 16'h0001, 2'b11);
        read_chk({2'd0, 12'hFFF, 9'h1FF}, 16'h0001, "R4 top row and column");
        read_chk({2'd2, 12'h123, 9'h045}, key(2'd2, 12'h123, 9'h045) ^ 16'hC3C3, "R8 unwritten location");
    endtask

    task automatic t_mask();
        logic [22:0] a;
        a = {2'd3, 12'h300, 9'h0AA};
        issue(1'b1, a, 16'hAAAA, 2'b11);
        issue(1'b1, a, 16'h1234, 2'b10);
        read_chk(a, 16'h12AA, "R7 upper byte only");
        issue(1'b1, a, 16'h5678, 2'b01);
        read_chk(a, 16'h1278, "R7 lower byte only");
        issue(1'b1, a, 16'hFFFF, 2'b00);
        read_chk(a, 16'h1278, "R7 both bytes masked");
    endtask

    task automatic t_banks();
        for (int b = 0; b < 4; b++)
            issue(1'b1, {2'(b), 12'h055, 9'h011}, 16'(16'hB000 + b), 2'b11);
        for (int b = 0; b < 4; b++)
            read_chk({2'(b), 12'h055, 9'h011}, 16'(16'hB000 + b), "R4 bank select");
    endtask

    task automatic t_refresh();
        int r0, bad;
        r0 = ref_cnt;
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            issue(1'b1, {2'(i), 12'(i * 7), 9'(i * 3)}, 16'(i * 16'h0101 + 3), 2'b11);
            issue(1'b0, {2'(i), 12'(i * 7), 9'(i * 3)}, 16'h0, 2'b11);
            begin
                int n;
                n = 0;
                while (!rd_valid && n < 100) begin @(negedge clk); n++; end
                if (!(rd_valid && rd_data == 16'(i * 16'h0101 + 3))) bad++;
            end
        end
        chk(bad == 0, "R9 data intact under refresh load", bad, 0);
        repeat (2 * TREFI) @(negedge clk);
        chk(ref_cnt - r0 >= 3, "R9 refreshes issued", ref_cnt - r0, 3);
        chk(iv_max <= TREFI + 30 && iv_min >= TREFI - 30, "R9 refresh interval", iv_max, TREFI);
    endtask

    task automatic t_final();
        chk(v_unk == 0, "R3 only legal command codes", v_unk, 0);
        chk(v_gap == 0, "R5 R6 command spacing", v_gap, 0);
        chk(v_bank == 0 && v_ap == 0, "R4 access to open bank with auto-precharge", v_bank + v_ap, 0);
        chk(v_intr == 0, "R9 nothing between activate and access", v_intr, 0);
        chk(v_lat == 0, "R8 read strobe latency", v_lat, 0);
        chk(v_oe == 0, "R7 bus driven only with write", v_oe, 0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_init();
        t_basic();
        t_mask();
        t_banks();
        t_refresh();
        t_final();
        finish_run();
    end

    initial begin
        #(20 * 150000);
        chk(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

endmodule